// File: doc/BRIEF.md
# Timing-Error Detecting Pipeline Register

This block sits at the boundary of one stage in a pipeline whose clock runs faster than the stage's worst-case delay allows. At the fast edge it takes a speculative copy of the stage result into the main register. Downstream logic can start using that copy at once. On a later enable edge, when the stage output is known to have settled, it takes a second copy into a shadow register. The two copies are then compared bit by bit.

When the copies agree, the speculative value stands and nothing else happens. When they differ, the block raises a one-cycle error pulse. This pulse tells the next stage to cancel the work it began from the wrong value and to start again. In the same cycle, the shadow value is written over the main register and also presented on a corrected-data output.

Each operation follows a fixed sequence: open with a main capture, close with a shadow capture, then one compare cycle. The block then accepts the next operation. A capture request that arrives outside its slot in this sequence is ignored. This keeps the shadow sample from ever being compared against data that belongs to a different operation.

Top module: `tsr_stage_reg`

## Requirements
- R1: After reset, `main_q_o`, `fix_q_o`, `err_o` and `fix_vld_o` are all zero, and the block is idle.
- R2: When the block is idle and `main_en` is high at a rising edge, `main_q_o` shows `stage_d` from that edge onward. This opens an operation.
- R3: When an operation is open and `shadow_en` is high at a rising edge, the shadow copy takes `stage_d` and `main_q_o` stays unchanged. The edge after this shadow capture is the compare edge.
- R4: At the compare edge, `err_o` rises for exactly that one cycle if any bit of the main copy differs from the shadow copy. If every bit agrees, `err_o` stays low.
- R5: At the compare edge, if the copies differ, `main_q_o` is overwritten with the shadow copy. If they agree, `main_q_o` keeps its value. Either way, `main_q_o` equals `fix_q_o` in the cycle after the compare edge.
- R6: At the compare edge, `fix_q_o` takes the shadow copy and `fix_vld_o` pulses high for one cycle.
- R7: `main_en` is ignored while an operation is open and during the compare cycle. `main_q_o` is not changed by it.
- R8: `shadow_en` is ignored while the block is idle: no compare follows, and `err_o`, `fix_vld_o` and `main_q_o` do not change.
- R9: `err_o` is never high in two consecutive cycles.
- R10: The block returns to idle after the compare edge. A `main_en` in the following cycle opens a new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast main clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stage_d | input | WIDTH | Output of the combinational stage |
| main_en | input | 1 | Speculative capture request (opens an operation) |
| shadow_en | input | 1 | Late safe capture request (closes an operation) |
| main_q_o | output | WIDTH | Main register value, repaired on error |
| err_o | output | 1 | One-cycle timing error pulse (cancel and replay downstream) |
| fix_q_o | output | WIDTH | Shadow-confirmed result of the latest operation |
| fix_vld_o | output | 1 | One-cycle pulse when `fix_q_o` is updated |

## Verification
The bench builds the block with WIDTH set to 4. At that width, every pairing of a speculative value with a shadow value can be run, which gives 256 operations. This covers agreeing copies, single-bit disagreements in each position and all-bit disagreements. The expected error flag and repaired value come from plain comparison in the bench. Separate sequences send capture requests outside their slot: main requests during the open and compare cycles, and shadow requests while idle. A reset is also applied in the middle of the run.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OPEN = 2'd1,
    ST_CMP  = 2'd2
  } tsr_state_e;

endpackage

// File: rtl/tsr_ctrl.sv
module tsr_ctrl
  import tsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic main_en,
  input  logic shadow_en,
  output logic main_take,
  output logic shadow_take,
  output logic cmp_now
);

  tsr_state_e state_q;
  tsr_state_e state_d;

  // operation sequence: open -> shadow close -> one compare cycle
  always_comb begin
    state_d     = state_q;
    main_take   = 1'b0;
    shadow_take = 1'b0;
    cmp_now     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (main_en) begin
          main_take = 1'b1;
          state_d   = ST_OPEN;
        end
      end
      ST_OPEN: begin
        if (shadow_en) begin
          shadow_take = 1'b1;
          state_d     = ST_CMP;
        end
      end
      ST_CMP: begin
        cmp_now = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/tsr_cmp.sv
module tsr_cmp #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             diff_o
);

  logic [WIDTH-1:0] bit_diff;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    assign bit_diff[g] = a_i[g] ^ b_i[g];
  end

  assign diff_o = |bit_diff;

endmodule

// File: rtl/tsr_regs.sv
module tsr_regs #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] stage_d,
  input  logic             main_take,
  input  logic             shadow_take,
  input  logic             cmp_now,
  input  logic             mismatch,
  output logic [WIDTH-1:0] main_q,
  output logic [WIDTH-1:0] shadow_q,
  output logic [WIDTH-1:0] fix_q,
  output logic             fix_vld_q,
  output logic             err_q
);

  logic [WIDTH-1:0] main_d;
  logic             main_ce;
  logic             repair;

  assign repair = cmp_now & mismatch;

  always_comb begin
    main_ce = main_take | repair;
    main_d  = main_take ? stage_d : shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       main_q <= '0;
    else if (main_ce) main_q <= main_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           shadow_q <= '0;
    else if (shadow_take) shadow_q <= stage_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fix_q <= '0;
    else if (cmp_now) fix_q <= shadow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q     <= 1'b0;
      fix_vld_q <= 1'b0;
    end else begin
      err_q     <= repair;
      fix_vld_q <= cmp_now;
    end
  end

endmodule

// File: rtl/tsr_stage_reg.sv
module tsr_stage_reg #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] stage_d,
  input  logic             main_en,
  input  logic             shadow_en,
  output logic [WIDTH-1:0] main_q_o,
  output logic             err_o,
  output logic [WIDTH-1:0] fix_q_o,
  output logic             fix_vld_o
);

  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  logic             main_take;
  logic             shadow_take;
  logic             cmp_now;
  logic             mismatch;
  logic [WIDTH-1:0] shadow_q;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  tsr_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .main_en     (main_en),
    .shadow_en   (shadow_en),
    .main_take   (main_take),
    .shadow_take (shadow_take),
    .cmp_now     (cmp_now)
  );

  tsr_cmp #(.WIDTH(WIDTH)) u_cmp (
    .a_i    (main_q_o),
    .b_i    (shadow_q),
    .diff_o (mismatch)
  );

  tsr_regs #(.WIDTH(WIDTH)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .stage_d     (stage_d),
    .main_take   (main_take),
    .shadow_take (shadow_take),
    .cmp_now     (cmp_now),
    .mismatch    (mismatch),
    .main_q      (main_q_o),
    .shadow_q    (shadow_q),
    .fix_q       (fix_q_o),
    .fix_vld_q   (fix_vld_o),
    .err_q       (err_o)
  );

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_o |=> !err_o); // R9

  AST_ERR_AFTER_SHADOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_o |-> $past(shadow_take, 2)); // R4

  AST_MAIN_HELD_AT_SHADOW: assert property (@(posedge clk) disable iff (!rst_n_s)
    shadow_take |=> $stable(main_q_o)); // R3

  AST_REPAIRED_AGREES: assert property (@(posedge clk) disable iff (!rst_n_s)
    fix_vld_o |-> (main_q_o == fix_q_o)); // R5

  AST_ERR_WITH_FIX: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_o |-> fix_vld_o); // R6

endmodule

// File: tb/sim_tsr_stage_reg.sv
module sim_tsr_stage_reg;

  localparam int W = 4;
  localparam int N = 1 << W;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] stage_d;
  logic         main_en;
  logic         shadow_en;
  logic [W-1:0] main_q_o;
  logic         err_o;
  logic [W-1:0] fix_q_o;
  logic         fix_vld_o;

  int total = 0;
  int bad   = 0;

  tsr_stage_reg #(.WIDTH(W)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .stage_d   (stage_d),
    .main_en   (main_en),
    .shadow_en (shadow_en),
    .main_q_o  (main_q_o),
    .err_o     (err_o),
    .fix_q_o   (fix_q_o),
    .fix_vld_o (fix_vld_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock: inputs change at negedge, outputs sampled at the next negedge
  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset;
    main_en   = 1'b0;
    shadow_en = 1'b0;
    stage_d   = '0;
    rst_n     = 1'b0;
    step();
    step();
    rst_n = 1'b1;
    step();
    step();
    step();
    chk("R1 main", int'(main_q_o), 0);
    chk("R1 fix", int'(fix_q_o), 0);
    chk("R1 err", int'(err_o), 0);
    chk("R1 vld", int'(fix_vld_o), 0);
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b);
    stage_d = a; main_en = 1'b1;
    step();
    main_en = 1'b0;
    chk("R2 capture", int'(main_q_o), int'(a));
    stage_d = b; shadow_en = 1'b1;
    step();
    shadow_en = 1'b0;
    chk("R3 main kept", int'(main_q_o), int'(a));
    chk("R4 no early err", int'(err_o), 0);
    step();
    chk("R4 err", int'(err_o), int'(a != b));
    chk("R5 main repaired", int'(main_q_o), int'(b));
    chk("R6 fix", int'(fix_q_o), int'(b));
    chk("R6 vld", int'(fix_vld_o), 1);
    step();
    chk("R9 err drop", int'(err_o), 0);
    chk("R6 vld drop", int'(fix_vld_o), 0);
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();

    // exhaustive speculative/shadow pairs (R2..R6, R9, R10 back-to-back)
    for (int a = 0; a < N; a++) begin
      for (int b = 0; b < N; b++) begin
        run_op(W'(a), W'(b));
      end
    end

    // R7: main_en during open and compare cycles
    stage_d = 4'h3; main_en = 1'b1;
    step();
    stage_d = 4'hC;
    step();
    chk("R7 open ignore", int'(main_q_o), 3);
    main_en = 1'b0; stage_d = 4'h5; shadow_en = 1'b1;
    step();
    shadow_en = 1'b0; main_en = 1'b1; stage_d = 4'hA;
    step();
    main_en = 1'b0;
    chk("R7 cmp ignore", int'(main_q_o), 5);
    chk("R4 err 3v5", int'(err_o), 1);
    step();
    chk("R7 after cmp", int'(main_q_o), 5);

    // R8: shadow_en while idle
    stage_d = 4'h9; shadow_en = 1'b1;
    step();
    shadow_en = 1'b0;
    step();
    chk("R8 err", int'(err_o), 0);
    chk("R8 vld", int'(fix_vld_o), 0);
    chk("R8 main", int'(main_q_o), 5);
    step();
    chk("R8 err late", int'(err_o), 0);
    chk("R8 vld late", int'(fix_vld_o), 0);

    // R10: block is idle again, next op opens normally
    run_op(4'hF, 4'h7);

    // R1: reset in the middle of the run
    do_reset();
    run_op(4'h1, 4'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule